// File: doc/BRIEF.md
# Mantissa Rounding Stage with Mode-Driven Overflow Policy

This block is a purely combinational rounding step for a floating-point result path. The caller supplies a mantissa that carries two extra low-order bits below the target precision, called guard and round. It also supplies a separate sticky bit that summarises everything shifted out earlier, the sign of the value and a two-bit rounding-mode code. The stage discards the two extra bits. It then decides from the mode, the sign and the discarded bits whether to add one at the new least significant position.

The outputs are the rounded mantissa, a flag telling the caller that an increment took place, and a flag telling it that the result differs from the exact value. A carry bit reports when the increment ran off the top of the mantissa, which is the "2.0" case. The caller must renormalise that case and bump its exponent, because this stage leaves it alone. The stage also gives, for the current mode and sign, the policy a caller applies on exponent overflow: infinity or the largest finite magnitude. Exponent handling and packing remain with the caller. All outputs are valid in the same cycle as the inputs.

Top module: `mant_round_unit`

## Requirements
- R1: Whenever no increment is applied, `mant_o` equals `mant_i` shifted right by two bits (bits MANT_W+1..2), `carry_o` is 0, and the sticky input never changes the mantissa value itself.
- R2: When `mant_i[1]` (guard), `mant_i[0]` (round) and `sticky_i` are all 0, `up_o` is 0 and `inexact_o` is 0 in every mode.
- R3: When any of guard, round or sticky is 1, `inexact_o` is 1 in every mode.
- R4: With `mode_i` = 0 (nearest, ties to even), `up_o` is 1 exactly when guard is 1 and at least one of round, sticky or `mant_i[2]` (the kept least significant bit) is 1.
- R5: With `mode_i` = 1 (toward zero), `up_o` is always 0.
- R6: With `mode_i` = 2 (toward plus infinity), `up_o` equals inexact AND NOT `sign_i`. With `mode_i` = 3 (toward minus infinity), `up_o` equals inexact AND `sign_i`.
- R7: When `up_o` is 1, `{carry_o, mant_o}` equals the shifted mantissa plus one over MANT_W+1 bits. This sets `carry_o` to 1 with `mant_o` all zero exactly when the shifted mantissa was all ones.
- R8: `ovf_inf_o` is 1 in mode 0 and 0 in mode 1. In mode 2 it is the inverse of `sign_i`, and in mode 3 it equals `sign_i`.
- R9: All outputs are combinational functions of the current inputs, with no clock or state, and settle in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mant_i | input | MANT_W+2 | Mantissa with guard at bit 1 and round at bit 0 |
| sticky_i | input | 1 | OR of all bits lost before this stage |
| mode_i | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_o | output | MANT_W | Rounded mantissa with guard and round dropped |
| carry_o | output | 1 | Increment overflowed the mantissa width |
| up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Guard, round or sticky was nonzero |
| ovf_inf_o | output | 1 | On exponent overflow, produce infinity (1) or largest finite (0) |

## Verification
The block holds no state, so any wrong decision appears on the outputs in the same evaluation as the input pattern that triggers it. Two kinds of fault hide easily in random data: a wrong tie decision in nearest mode and a broken carry chain. A wrong tie decision shows only when guard is set while round and sticky are clear. A broken carry chain shows only on long runs of ones, because a break in bit k shows up only when bits below k are all ones. The bench therefore weights its stimulus toward those patterns and mode/sign pairings, and it checks every output on every vector.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_POS  = 2'd2,
        RM_NEG  = 2'd3
    } rnd_mode_e;

    // Number of low bits below target precision (guard, round).
    localparam int unsigned EXTRA_W = 2;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
(
    input  rnd_mode_e mode_i,
    input  logic      sign_i,
    input  logic      guard_i,
    input  logic      round_i,
    input  logic      sticky_i,
    input  logic      lsb_i,
    output logic      inc_o,
    output logic      inexact_o
);

    typedef struct packed {
        logic inc;
        logic inexact;
    } dec_t;

    dec_t dec_d;

    always_comb begin
        dec_d         = '0;
        dec_d.inexact = guard_i | round_i | sticky_i;
        unique case (mode_i)
            RM_ZERO: dec_d.inc = 1'b0;
            RM_POS:  dec_d.inc = dec_d.inexact & ~sign_i;
            RM_NEG:  dec_d.inc = dec_d.inexact & sign_i;
            default: dec_d.inc = guard_i & (round_i | sticky_i | lsb_i);
        endcase
    end

    assign inc_o     = dec_d.inc;
    assign inexact_o = dec_d.inexact;

    // R2: an exact input never increments
    always_comb begin
        p_exact_no_inc_r2: assert (guard_i || round_i || sticky_i || !inc_o)
            else $error("exact input incremented");
        // R5: toward-zero never increments
        p_rtz_no_inc_r5: assert (!(mode_i == RM_ZERO && inc_o))
            else $error("toward-zero incremented");
        // R4: nearest never increments with guard clear
        p_near_guard_r4: assert (!(mode_i == RM_NEAR && !guard_i && inc_o))
            else $error("nearest incremented below half");
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] vec_i,
    input  logic         inc_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);

    logic [W:0] chain;

    assign chain[0] = inc_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i]    = vec_i[i] ^ chain[i];
        assign chain[i+1]  = vec_i[i] & chain[i];
    end

    assign carry_o = chain[W];

    // R7: carry-out only from an all-ones operand with increment
    always_comb begin
        p_carry_wraps_r7: assert (!carry_o || (inc_i && sum_o == '0 && &vec_i))
            else $error("carry without all-ones increment");
    end

endmodule

// File: rtl/rnd_ovf_policy.sv
module rnd_ovf_policy
    import rnd_pkg::*;
(
    input  rnd_mode_e mode_i,
    input  logic      sign_i,
    output logic      to_inf_o
);

    always_comb begin
        unique case (mode_i)
            RM_ZERO: to_inf_o = 1'b0;
            RM_POS:  to_inf_o = ~sign_i;
            RM_NEG:  to_inf_o = sign_i;
            default: to_inf_o = 1'b1;
        endcase
    end

    // R8: nearest always overflows to infinity
    always_comb begin
        p_near_to_inf_r8: assert (mode_i != RM_NEAR || to_inf_o)
            else $error("nearest overflow not infinite");
    end

endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
    import rnd_pkg::*;
#(
    parameter int unsigned MANT_W = 24
) (
    input  logic                      sign_i,
    input  logic [MANT_W+EXTRA_W-1:0] mant_i,
    input  logic                      sticky_i,
    input  logic [1:0]                mode_i,
    output logic [MANT_W-1:0]         mant_o,
    output logic                      carry_o,
    output logic                      up_o,
    output logic                      inexact_o,
    output logic                      ovf_inf_o
);

    localparam int unsigned IN_W = MANT_W + EXTRA_W;

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic              carry;
        logic              up;
        logic              inexact;
        logic              to_inf;
    } res_t;

    rnd_mode_e         mode_d;
    logic [MANT_W-1:0] kept_d;
    logic [MANT_W-1:0] sum_d;
    logic              inc_d;
    logic              inexact_d;
    logic              carry_d;
    logic              to_inf_d;
    res_t              res_d;

    assign mode_d = rnd_mode_e'(mode_i);
    assign kept_d = mant_i[IN_W-1:EXTRA_W];

    rnd_decide u_decide (
        .mode_i    (mode_d),
        .sign_i    (sign_i),
        .guard_i   (mant_i[1]),
        .round_i   (mant_i[0]),
        .sticky_i  (sticky_i),
        .lsb_i     (mant_i[EXTRA_W]),
        .inc_o     (inc_d),
        .inexact_o (inexact_d)
    );

    rnd_incr #(.W(MANT_W)) u_incr (
        .vec_i   (kept_d),
        .inc_i   (inc_d),
        .sum_o   (sum_d),
        .carry_o (carry_d)
    );

    rnd_ovf_policy u_ovf (
        .mode_i   (mode_d),
        .sign_i   (sign_i),
        .to_inf_o (to_inf_d)
    );

    always_comb begin
        res_d         = '0;
        res_d.mant    = sum_d;
        res_d.carry   = carry_d;
        res_d.up      = inc_d;
        res_d.inexact = inexact_d;
        res_d.to_inf  = to_inf_d;
    end

    assign mant_o    = res_d.mant;
    assign carry_o   = res_d.carry;
    assign up_o      = res_d.up;
    assign inexact_o = res_d.inexact;
    assign ovf_inf_o = res_d.to_inf;

    always_comb begin
        // R1: no increment means a plain two-bit shift
        p_plain_shift_r1: assert (up_o || (mant_o == mant_i[IN_W-1:EXTRA_W] && !carry_o))
            else $error("unrounded mantissa altered");
        // R3: an increment always comes with inexact
        p_up_needs_inexact_r3: assert (!up_o || inexact_o)
            else $error("increment on exact value");
    end

endmodule

// File: tb/sim_mant_round_unit.sv
module sim_mant_round_unit;

    localparam int unsigned MW = 24;
    localparam int unsigned IW = MW + 2;

    logic          clk = 1'b0;
    logic          sign_i;
    logic [IW-1:0] mant_i;
    logic          sticky_i;
    logic [1:0]    mode_i;
    logic [MW-1:0] mant_o;
    logic          carry_o;
    logic          up_o;
    logic          inexact_o;
    logic          ovf_inf_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk; // 125 MHz

    mant_round_unit #(.MANT_W(MW)) u0 (
        .sign_i    (sign_i),
        .mant_i    (mant_i),
        .sticky_i  (sticky_i),
        .mode_i    (mode_i),
        .mant_o    (mant_o),
        .carry_o   (carry_o),
        .up_o      (up_o),
        .inexact_o (inexact_o),
        .ovf_inf_o (ovf_inf_o)
    );

    function automatic logic exp_inexact(logic [IW-1:0] m, logic s);
        return (m[1:0] != 2'b00) || s;
    endfunction

    function automatic logic exp_up(logic sg, logic [IW-1:0] m, logic s, logic [1:0] md);
        logic half_or_more, above_half, odd;
        half_or_more = m[1];
        above_half   = m[0] || s;
        odd          = m[2];
        case (md)
            2'd0:    return half_or_more && (above_half || odd);
            2'd1:    return 1'b0;
            2'd2:    return exp_inexact(m, s) && !sg;
            default: return exp_inexact(m, s) && sg;
        endcase
    endfunction

    function automatic logic exp_inf(logic sg, logic [1:0] md);
        case (md)
            2'd0:    return 1'b1;
            2'd1:    return 1'b0;
            2'd2:    return !sg;
            default: return sg;
        endcase
    endfunction

    task automatic check(string tag, logic [MW:0] act, logic [MW:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (mode=%0d sign=%0b mant=%h sticky=%0b)",
                     tag, act, exp, mode_i, sign_i, mant_i, sticky_i);
        end
    endtask

    task automatic apply(logic sg, logic [IW-1:0] m, logic s, logic [1:0] md);
        logic          u;
        logic [MW:0]   val;
        string         utag;
        @(negedge clk);
        sign_i = sg; mant_i = m; sticky_i = s; mode_i = md;
        @(posedge clk);
        #1;
        u   = exp_up(sg, m, s, md);
        val = {1'b0, m[IW-1:2]} + {{MW{1'b0}}, u};
        case (md)
            2'd0:    utag = "R4 up";
            2'd1:    utag = "R5 up";
            default: utag = "R6 up";
        endcase
        // R9: outputs already valid in the cycle the inputs are applied
        check(utag, {{MW{1'b0}}, up_o}, {{MW{1'b0}}, u});
        check(u ? "R7 sum" : "R1 shift", {carry_o, mant_o}, val);
        check(exp_inexact(m, s) ? "R3 inexact" : "R2 inexact",
              {{MW{1'b0}}, inexact_o}, {{MW{1'b0}}, exp_inexact(m, s)});
        check("R8 ovf", {{MW{1'b0}}, ovf_inf_o}, {{MW{1'b0}}, exp_inf(sg, md)});
    endtask

    initial begin
        #1500000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [IW-1:0] ones;
        int seed;
        ones = '1;
        seed = 1234;
        void'($urandom(seed));
        sign_i = 0; mant_i = '0; sticky_i = 0; mode_i = 0;
        // R2: exact zero in every mode, both signs
        for (int md = 0; md < 4; md++) begin
            apply(1'b0, '0, 1'b0, md[1:0]);
            apply(1'b1, {ones[IW-1:2], 2'b00}, 1'b0, md[1:0]);
        end
        // R4: ties to even, odd and even kept LSB
        apply(1'b0, {{(IW-3){1'b0}}, 3'b010}, 1'b0, 2'd0);
        apply(1'b0, {{(IW-3){1'b0}}, 3'b110}, 1'b0, 2'd0);
        apply(1'b1, {{(IW-3){1'b0}}, 3'b010}, 1'b1, 2'd0);
        apply(1'b0, {{(IW-3){1'b0}}, 3'b001}, 1'b1, 2'd0);
        // R3/R5/R6: sticky only, each mode and sign
        for (int md = 0; md < 4; md++)
            for (int sg = 0; sg < 2; sg++)
                apply(sg[0], {{(IW-3){1'b0}}, 3'b100}, 1'b1, md[1:0]);
        // R7: all-ones carry out in every mode and sign
        for (int md = 0; md < 4; md++)
            for (int sg = 0; sg < 2; sg++)
                apply(sg[0], ones, 1'b1, md[1:0]);
        // R7: partial runs of ones exercise each carry position
        for (int k = 1; k < MW; k++)
            apply(1'b0, ((IW'(1) << (k + 2)) - IW'(1)), 1'b0, 2'd2);
        // Random mix, biased toward tie patterns and long ones runs
        for (int n = 0; n < 3000; n++) begin
            logic [IW-1:0] m;
            logic          s;
            m = IW'({$urandom, $urandom});
            s = $urandom_range(0, 1) == 1;
            case ($urandom_range(0, 3))
                0: begin m[1:0] = 2'b10; s = 1'b0; end
                1: m = m | (ones >> $urandom_range(2, IW - 1));
                default: ;
            endcase
            apply($urandom_range(0, 1) == 1, m, s, 2'($urandom_range(0, 3)));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule